// File: doc/BRIEF.md
# Remote terminal address and status-flag register

This block is the 16-bit host register of a serial-bus remote terminal that carries the terminal's own address and the flags reported back in its status word. After master reset it captures the 5-bit address and an odd-parity bit from strap pins. It also captures the initial controller/terminal mode from a select pin. Later host writes may replace the address and parity, unless a hardware lock-out pin is high. One clock after every address capture, the block checks the address and parity bits and records a parity-error bit.

The upper seven bits are host-set flags. They drive the instrumentation, service-request, busy, subsystem, terminal and dynamic-bus-control acceptance bits of the outgoing status word. One of them also drives a transfer-inhibit signal toward the subsystem.

A small state machine sequences the captures and the check. The states are LOAD, CHECK and IDLE. LOAD is entered during reset, captures the pins on the first clock and always moves to CHECK. CHECK evaluates parity. It moves to IDLE, or stays in CHECK if another permitted address write arrives in the same cycle. IDLE moves to CHECK on a permitted address write and otherwise stays in IDLE.

Top module: `rt_addr_ctl`

## Requirements
- R1: On the first clock after reset is released, address bits [4:0] load from `addr_pins`, bit 5 loads from `par_pin`, `mode_rt` loads from `modesel_pin`, and flag bits [15:9] are zero.
- R2: A host write with `lock_pin` low updates bits [4:0] and bit 5 from `wr_data`. Flag bits [15:9] take `wr_data[15:9]` on every host write, whatever the lock state.
- R3: While `lock_pin` is high, host writes leave bits [5:0] unchanged, and `mode_wr_en` leaves `mode_rt` unchanged.
- R4: Bit 6 (parity error) is 1 when bits [5:0] hold an even number of ones. It is updated on the clock after the address is latched and keeps its previous value until then.
- R5: Bit 8 reads `modesel_pin` and bit 7 reads `lock_pin`. Written values of bits 8, 7 and 6 are ignored.
- R6: `sw_busy` is bit 14 OR bit 9. `xfer_inhibit` follows bit 9 only.
- R7: `sw_ssf` follows bit 13. `msg_ssf_log` is bit 13 AND `mode_rt`.
- R8: `sw_tf` is bit 11 OR `bist_fail`.
- R9: `sw_dbca` is high only while bit 12 is set and `dbc_strobe` is high.
- R10: `sw_instr` follows bit 15 and `sw_srq` follows bit 10.
- R11: `mode_wr_en` with `lock_pin` low loads `mode_wr_val` into `mode_rt` (1 = terminal mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low |
| addr_pins | input | 5 | Strapped terminal address |
| par_pin | input | 1 | Strapped odd-parity bit |
| lock_pin | input | 1 | Hardware lock-out of address and mode |
| modesel_pin | input | 1 | Strapped controller/terminal select |
| wr_en | input | 1 | Host register write strobe |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Register read value |
| mode_wr_en | input | 1 | Host mode-select write strobe |
| mode_wr_val | input | 1 | Mode value to write (1 = terminal) |
| bist_fail | input | 1 | Built-in test failure |
| dbc_strobe | input | 1 | Dynamic bus control mode code received from active controller |
| mode_rt | output | 1 | Active mode, 1 = terminal |
| sw_instr | output | 1 | Status-word instrumentation bit |
| sw_srq | output | 1 | Status-word service request bit |
| sw_busy | output | 1 | Status-word busy bit |
| sw_ssf | output | 1 | Status-word subsystem flag |
| sw_dbca | output | 1 | Status-word dynamic bus control acceptance |
| sw_tf | output | 1 | Status-word terminal flag |
| xfer_inhibit | output | 1 | Blocks data transfers to the subsystem |
| msg_ssf_log | output | 1 | Subsystem flag for message-status logging |

## Verification
The bench builds the block with the package defaults: a 5-bit address field inside a 16-bit register. At that size, odd and even parity cases, the all-zero address and all-flags-set words can each be reached in a single write. A strap value is chosen so that the reset path lands on valid parity. The stale parity-error cycle after a write is sampled explicitly, along with lock-blocked writes of both address and mode.

// File: rtl/rt_addr_pkg.sv
package rt_addr_pkg;
    localparam int ADDR_W   = 5;
    localparam int REG_W    = 16;
    localparam int PAR_BIT  = ADDR_W;
    localparam int PERR_BIT = ADDR_W + 1;
    localparam int LOCK_BIT = ADDR_W + 2;
    localparam int SEL_BIT  = ADDR_W + 3;
    localparam int FLAG_LO  = ADDR_W + 4;
    localparam int FLAG_W   = REG_W - FLAG_LO;
    // flag offsets inside the flag field
    localparam int F_BUSYINH = 0;
    localparam int F_SRQ     = 1;
    localparam int F_TF      = 2;
    localparam int F_DBCA    = 3;
    localparam int F_SSF     = 4;
    localparam int F_BUSY    = 5;
    localparam int F_INSTR   = 6;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_CHECK = 2'd1,
        ST_IDLE  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/rt_addr_fsm.sv
module rt_addr_fsm
    import rt_addr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_wr_req,
    output logic       latch_pins,
    output logic       check_en,
    output logic       addr_wr_ok
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        latch_pins = 1'b0;
        check_en   = 1'b0;
        addr_wr_ok = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                latch_pins = 1'b1;
                state_d    = ST_CHECK;
            end
            ST_CHECK: begin
                check_en   = 1'b1;
                addr_wr_ok = addr_wr_req;
                state_d    = addr_wr_req ? ST_CHECK : ST_IDLE;
            end
            ST_IDLE: begin
                addr_wr_ok = addr_wr_req;
                state_d    = addr_wr_req ? ST_CHECK : ST_IDLE;
            end
            default: state_d = ST_LOAD;
        endcase
    end
endmodule

// File: rtl/rt_par_chk.sv
module rt_par_chk
    import rt_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              check_en,
    input  logic [ADDR_W:0]   code_bits,
    output logic              par_err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        par_err <= 1'b0;
        else if (check_en) par_err <= ~(^code_bits);
    end
endmodule

// File: rtl/rt_sw_map.sv
module rt_sw_map
    import rt_addr_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  logic              mode_rt,
    input  logic              bist_fail,
    input  logic              dbc_strobe,
    output logic              sw_instr,
    output logic              sw_srq,
    output logic              sw_busy,
    output logic              sw_ssf,
    output logic              sw_dbca,
    output logic              sw_tf,
    output logic              xfer_inhibit,
    output logic              msg_ssf_log
);
    always_comb begin
        sw_instr     = flags[F_INSTR];
        sw_srq       = flags[F_SRQ];
        sw_busy      = flags[F_BUSY] | flags[F_BUSYINH];
        xfer_inhibit = flags[F_BUSYINH];
        sw_ssf       = flags[F_SSF];
        msg_ssf_log  = flags[F_SSF] & mode_rt;
        sw_tf        = flags[F_TF] | bist_fail;
        sw_dbca      = flags[F_DBCA] & dbc_strobe;
    end
endmodule

// File: rtl/rt_addr_ctl.sv
module rt_addr_ctl
    import rt_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_pins,
    input  logic              par_pin,
    input  logic              lock_pin,
    input  logic              modesel_pin,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              mode_wr_en,
    input  logic              mode_wr_val,
    input  logic              bist_fail,
    input  logic              dbc_strobe,
    output logic              mode_rt,
    output logic              sw_instr,
    output logic              sw_srq,
    output logic              sw_busy,
    output logic              sw_ssf,
    output logic              sw_dbca,
    output logic              sw_tf,
    output logic              xfer_inhibit,
    output logic              msg_ssf_log
);
    logic [ADDR_W-1:0] addr_q;
    logic              par_q;
    logic [FLAG_W-1:0] flags_q;
    logic              mode_q;
    logic              latch_pins, check_en, addr_wr_ok, par_err;

    rt_addr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_wr_req(wr_en & ~lock_pin),
        .latch_pins (latch_pins),
        .check_en   (check_en),
        .addr_wr_ok (addr_wr_ok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            par_q   <= 1'b0;
            flags_q <= '0;
            mode_q  <= 1'b0;
        end else if (latch_pins) begin
            addr_q  <= addr_pins;
            par_q   <= par_pin;
            mode_q  <= modesel_pin;
        end else begin
            if (wr_en)
                flags_q <= wr_data[REG_W-1:FLAG_LO];
            if (addr_wr_ok) begin
                addr_q <= wr_data[ADDR_W-1:0];
                par_q  <= wr_data[PAR_BIT];
            end
            if (mode_wr_en && !lock_pin)
                mode_q <= mode_wr_val;
        end
    end

    rt_par_chk u_par (
        .clk      (clk),
        .rst_n    (rst_n),
        .check_en (check_en),
        .code_bits({par_q, addr_q}),
        .par_err  (par_err)
    );

    rt_sw_map u_map (
        .flags       (flags_q),
        .mode_rt     (mode_q),
        .bist_fail   (bist_fail),
        .dbc_strobe  (dbc_strobe),
        .sw_instr    (sw_instr),
        .sw_srq      (sw_srq),
        .sw_busy     (sw_busy),
        .sw_ssf      (sw_ssf),
        .sw_dbca     (sw_dbca),
        .sw_tf       (sw_tf),
        .xfer_inhibit(xfer_inhibit),
        .msg_ssf_log (msg_ssf_log)
    );

    assign mode_rt = mode_q;
    assign rd_data = {flags_q, modesel_pin, lock_pin, par_err, par_q, addr_q};
endmodule

// File: rtl/rt_addr_ctl_chk.sv
module rt_addr_ctl_chk
    import rt_addr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             lock_pin,
    input logic             modesel_pin,
    input logic             wr_en,
    input logic             mode_wr_en,
    input logic             loading,
    input logic [REG_W-1:0] rd_data,
    input logic             mode_rt,
    input logic             bist_fail,
    input logic             dbc_strobe,
    input logic             sw_busy,
    input logic             sw_tf,
    input logic             sw_dbca,
    input logic             xfer_inhibit
);
    assert_lock_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_pin && !loading) |=> rd_data[PAR_BIT:0] == $past(rd_data[PAR_BIT:0]));

    assert_lock_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_pin && !loading) |=> mode_rt == $past(mode_rt));

    assert_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !lock_pin && !loading) ##1 !(wr_en && !lock_pin)
        |=> rd_data[PERR_BIT] == ~(^rd_data[PAR_BIT:0]));

    assert_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[LOCK_BIT] == lock_pin && rd_data[SEL_BIT] == modesel_pin);

    assert_inhibit_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_inhibit |-> sw_busy);

    assert_bist_tf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bist_fail |-> sw_tf);

    assert_dbca_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_dbca |-> dbc_strobe);
endmodule

bind rt_addr_ctl rt_addr_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_pin    (lock_pin),
    .modesel_pin (modesel_pin),
    .wr_en       (wr_en),
    .mode_wr_en  (mode_wr_en),
    .loading     (latch_pins),
    .rd_data     (rd_data),
    .mode_rt     (mode_rt),
    .bist_fail   (bist_fail),
    .dbc_strobe  (dbc_strobe),
    .sw_busy     (sw_busy),
    .sw_tf       (sw_tf),
    .sw_dbca     (sw_dbca),
    .xfer_inhibit(xfer_inhibit)
);

// File: tb/rt_addr_ctl_bench.sv
module rt_addr_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr_pins = 5'h15;
    logic        par_pin = 1'b0;
    logic        lock_pin = 1'b0;
    logic        modesel_pin = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        mode_wr_en = 1'b0;
    logic        mode_wr_val = 1'b0;
    logic        bist_fail = 1'b0;
    logic        dbc_strobe = 1'b0;
    logic        mode_rt, sw_instr, sw_srq, sw_busy, sw_ssf, sw_dbca, sw_tf;
    logic        xfer_inhibit, msg_ssf_log;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rt_addr_ctl u_rt_addr_ctl (.*);

    // {lock, write data, expected read value}
    localparam logic [32:0] VEC [5] = '{
        {1'b0, 16'h0003, 16'h0143},
        {1'b0, 16'h0023, 16'h0123},
        {1'b1, 16'h001F, 16'h01A3},
        {1'b0, 16'h81C0, 16'h8140},
        {1'b0, 16'hFE3E, 16'hFF3E}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic lk, input logic [15:0] d);
        @(negedge clk);
        lock_pin = lk; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 strapped load: address 0x15, parity 0 (odd count) so R4 error clear
        chk("R1 reset read", rd_data, 16'h0115);
        chk("R1 mode", {15'd0, mode_rt}, 16'd1);
        chk("R1 flags clear", {8'd0, sw_instr, sw_srq, sw_busy, sw_ssf, sw_dbca,
            sw_tf, xfer_inhibit, msg_ssf_log}, 16'd0);

        for (int i = 0; i < 5; i++) begin
            host_wr(VEC[i][32], VEC[i][31:16]);
            @(negedge clk);
            chk("R2 R3 R4 R5 vector", rd_data, VEC[i][15:0]);
        end
        lock_pin = 1'b0;
        // after last vector every flag set
        chk("R10 instr/srq", {14'd0, sw_instr, sw_srq}, 16'h3);
        chk("R6 busy/inhibit", {14'd0, sw_busy, xfer_inhibit}, 16'h3);
        chk("R7 ssf/log", {14'd0, sw_ssf, msg_ssf_log}, 16'h3);
        chk("R8 tf from flag", {15'd0, sw_tf}, 16'd1);
        chk("R9 dbca no strobe", {15'd0, sw_dbca}, 16'd0);
        dbc_strobe = 1'b1; #1;
        chk("R9 dbca strobe", {15'd0, sw_dbca}, 16'd1);
        dbc_strobe = 1'b0;

        // R6 plain busy without inhibit; R4 stale value for one cycle
        host_wr(1'b0, 16'h4000);
        chk("R4 stale perr", {15'd0, rd_data[6]}, 16'd0);
        @(negedge clk);
        chk("R4 perr updated", rd_data, 16'h4140);
        chk("R6 busy only", {14'd0, sw_busy, xfer_inhibit}, 16'h2);

        // R8 bist failure forces terminal flag
        bist_fail = 1'b1; #1;
        chk("R8 tf from bist", {15'd0, sw_tf}, 16'd1);
        bist_fail = 1'b0; #1;
        chk("R8 tf clear", {15'd0, sw_tf}, 16'd0);

        // R11 / R3 mode writes
        @(negedge clk);
        lock_pin = 1'b1; mode_wr_en = 1'b1; mode_wr_val = 1'b0;
        @(negedge clk);
        mode_wr_en = 1'b0;
        chk("R3 mode locked", {15'd0, mode_rt}, 16'd1);
        lock_pin = 1'b0; mode_wr_en = 1'b1;
        @(negedge clk);
        mode_wr_en = 1'b0;
        chk("R11 mode write", {15'd0, mode_rt}, 16'd0);
        host_wr(1'b0, 16'h2000);
        @(negedge clk);
        chk("R7 ssf not logged in controller mode", {14'd0, sw_ssf, msg_ssf_log}, 16'h2);
        finish_run();
    end
endmodule